// File: doc/BRIEF.md
# Serial EEPROM Boot Configuration Loader

This block fills a 128-entry configuration register file from an external serial EEPROM. Once reset is released, it checks its two mode-select inputs and a power-down request. If the mode inputs are 00 and power-down is not requested, it acts as the I2C master on the bus. It reads the EEPROM from word address 0 in one random-read transaction and passes each data byte to a register write port.

The first EEPROM byte is a signature. It must equal 0x95. If it matches, the bytes that follow are written to registers 0 to 127, one write strobe per byte. If it does not match, the whole transfer still runs to its end, but no register is written. If the EEPROM fails to acknowledge any addressing byte, the loader issues STOP and gives up.

Two status outputs report the result. `load_done` rises once the loader has finished. `load_valid` rises with it only when the register file holds a complete image.

The block drives the bus as open drain. Each line has a drive-low enable, and SDA also has a sampled input. The SCL rate comes from a parameterised divider of the system clock. The loader does not support clock stretching and does not arbitrate against other masters.

Top module: `boot_cfg_loader`

## Requirements
- R1: After reset is deasserted, with `mode_sel` = 00 and `pwr_down` low, the loader starts on its own with a START condition (SDA falls while SCL is high).
- R2: The bus transaction is, in order: START, byte 0xA0 (device address 0x50 with write bit 0), word address byte 0x00, repeated START, byte 0xA1 (read bit 1), 129 read bytes, STOP. The whole load contains exactly two START conditions and one STOP condition.
- R3: SDA changes only while SCL is low, except at START and STOP conditions.
- R4: When byte 0 equals 0x95, EEPROM byte N (N = 1..128) is written to register N−1. The writes come in ascending address order, one `reg_we` pulse each, 128 writes in total, and `load_valid` is 1 when `load_done` rises.
- R5: When byte 0 differs from 0x95, no `reg_we` pulse occurs, and `load_done` rises with `load_valid` at 0.
- R6: The loader answers each of the first 128 read bytes with ACK (SDA low on the ninth clock) and the 129th with NACK (SDA released), then issues STOP.
- R7: If the EEPROM does not acknowledge the write-address byte, the word-address byte or the read-address byte, the loader issues STOP, writes no register, and raises `load_done` with `load_valid` at 0.
- R8: While `pwr_down` is 1 after reset, the loader does not drive SCL or SDA and `load_done` stays 0. Once `pwr_down` falls, the load runs normally.
- R9: With `mode_sel` other than 00, the loader never drives the bus and `load_done` stays 0.
- R10: A full load finishes within 30 ms, i.e. `SYS_CLK_HZ*30/1000` clock cycles after the load starts.
- R11: During reset, all outputs are low. After `load_done` rises, it and `load_valid` keep their values until the next reset, and `load_valid` is never 1 while `load_done` is 0.
- R12: Within a byte, consecutive SCL rising edges are `4*QTR_DIV` clock cycles apart, where `QTR_DIV = SYS_CLK_HZ/(4*SCL_HZ)`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; the load starts after it is released |
| mode_sel | input | 2 | Configuration-interface mode; 00 selects EEPROM loading |
| pwr_down | input | 1 | Power-down request; while 1, the load is held off |
| scl_oe | output | 1 | Pull SCL low when 1, release when 0 |
| sda_oe | output | 1 | Pull SDA low when 1, release when 0 |
| sda_in | input | 1 | Sampled SDA line level |
| reg_addr | output | 7 | Register-file write address |
| reg_data | output | 8 | Register-file write data |
| reg_we | output | 1 | One-cycle register-file write strobe |
| load_done | output | 1 | Loader has finished (either outcome) |
| load_valid | output | 1 | Signature matched and every byte was acknowledged |

## Verification
The EEPROM model in the bench is filled with random images under a fixed seed. Two images carry the correct signature, which exercises the byte-to-register mapping with different data. Two images carry near-miss signatures (0x94 and 0x59), which shows that only the exact value opens the load. The model also withholds ACK on each of the three addressing bytes in turn, which separates the abort path from a signature failure. Power-down and non-zero mode runs show that the loader stays silent on the bus until it is allowed to run.

// File: rtl/boot_cfg_pkg.sv
package boot_cfg_pkg;

    typedef enum logic [1:0] {
        BC_START,
        BC_STOP,
        BC_WRITE,
        BC_READ
    } bus_cmd_e;

    typedef enum logic [3:0] {
        SQ_WAIT,
        SQ_START,
        SQ_DEVW,
        SQ_WADDR,
        SQ_RSTART,
        SQ_DEVR,
        SQ_READ,
        SQ_STOP,
        SQ_DONE
    } seq_state_e;

    // Line drive for one quarter phase: {scl_pull_low, sda_pull_low}.
    // Data bits hold SDA for all four phases; only START/STOP move SDA with SCL high.
    function automatic logic [1:0] phase_lines(bus_cmd_e c, logic [1:0] ph, logic [3:0] b,
                                               logic [7:0] wd, logic give_ack);
        logic clk_low;
        clk_low = (ph == 2'd0) || (ph == 2'd3);
        unique case (c)
            BC_START: begin
                unique case (ph)
                    2'd0:    return 2'b10;
                    2'd1:    return 2'b00;
                    2'd2:    return 2'b01;
                    default: return 2'b11;
                endcase
            end
            BC_STOP: begin
                unique case (ph)
                    2'd0:    return 2'b11;
                    2'd1:    return 2'b01;
                    default: return 2'b00;
                endcase
            end
            BC_WRITE: return {clk_low, (b < 4'd8) ? ~wd[3'd7 - b[2:0]] : 1'b0};
            default:  return {clk_low, (b == 4'd8) && give_ack};
        endcase
    endfunction

endpackage

// File: rtl/boot_cfg_tick.sv
module boot_cfg_tick #(
    parameter int unsigned QTR_DIV = 125
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned CW = (QTR_DIV > 1) ? $clog2(QTR_DIV) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    assign tick = (cnt_q == CW'(QTR_DIV - 1));

    always_comb begin
        cnt_d = tick ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    generate
        if (QTR_DIV > 1) begin : g_spacing
            // R12: quarter-phase strobes never come back to back
            a_r12_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/boot_cfg_bit_engine.sv
module boot_cfg_bit_engine
    import boot_cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       cmd_valid,
    input  bus_cmd_e   cmd,
    input  logic [7:0] wdata,
    input  logic       send_ack,
    input  logic       sda_in,
    output logic       done,
    output logic [7:0] rdata,
    output logic       nack,
    output logic       scl_oe,
    output logic       sda_oe
);
    typedef struct packed {
        logic       busy;
        bus_cmd_e   cmd;
        logic [1:0] ph;
        logic [3:0] bitn;
        logic [7:0] wdat;
        logic [7:0] rsh;
        logic       sack;
        logic       ackin;
        logic       done;
        logic       scl_oe;
        logic       sda_oe;
        logic       sda_s1;
        logic       sda_s2;
    } eng_s;

    eng_s q, n;
    logic last_bit;

    always_comb begin
        n        = q;
        n.done   = 1'b0;
        n.sda_s1 = sda_in;
        n.sda_s2 = q.sda_s1;
        last_bit = (q.cmd == BC_START) || (q.cmd == BC_STOP) || (q.bitn == 4'd8);
        if (!q.busy) begin
            if (cmd_valid) begin
                n.busy   = 1'b1;
                n.cmd    = cmd;
                n.ph     = 2'd0;
                n.bitn   = 4'd0;
                n.wdat   = wdata;
                n.sack   = send_ack;
                {n.scl_oe, n.sda_oe} = phase_lines(cmd, 2'd0, 4'd0, wdata, send_ack);
            end
        end else if (tick) begin
            if (q.ph == 2'd2) begin
                if (q.bitn < 4'd8) n.rsh   = {q.rsh[6:0], q.sda_s2};
                else               n.ackin = q.sda_s2;
            end
            if (q.ph == 2'd3 && last_bit) begin
                n.busy = 1'b0;
                n.done = 1'b1;
            end else begin
                n.ph = q.ph + 2'd1;
                if (q.ph == 2'd3) n.bitn = q.bitn + 4'd1;
                {n.scl_oe, n.sda_oe} = phase_lines(q.cmd, n.ph, n.bitn, q.wdat, q.sack);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.cmd  <= BC_STOP;
            q.sda_s1 <= 1'b1;
            q.sda_s2 <= 1'b1;
        end else begin
            q <= n;
        end
    end

    assign done   = q.done;
    assign rdata  = q.rsh;
    assign nack   = q.ackin;
    assign scl_oe = q.scl_oe;
    assign sda_oe = q.sda_oe;

    // R3: SDA may move under a released SCL only inside START or STOP
    a_r3_sda_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_oe && !$past(scl_oe) && (sda_oe != $past(sda_oe)))
        |-> (q.cmd == BC_START || q.cmd == BC_STOP));

    // R12: SCL moves only on a quarter strobe or when a command is accepted
    a_r12_scl_paced: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(scl_oe) |-> ($past(tick) || $past(cmd_valid)));

endmodule

// File: rtl/boot_cfg_loader.sv
module boot_cfg_loader
    import boot_cfg_pkg::*;
#(
    parameter int unsigned SYS_CLK_HZ = 50_000_000,
    parameter int unsigned SCL_HZ     = 100_000,
    parameter int unsigned NUM_REGS   = 128,
    parameter logic [6:0]  DEV_ADDR   = 7'h50,
    parameter logic [7:0]  SIGNATURE  = 8'h95
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_sel,
    input  logic       pwr_down,
    output logic       scl_oe,
    output logic       sda_oe,
    input  logic       sda_in,
    output logic [6:0] reg_addr,
    output logic [7:0] reg_data,
    output logic       reg_we,
    output logic       load_done,
    output logic       load_valid
);
    localparam int unsigned QTR_DIV    = SYS_CLK_HZ / (4 * SCL_HZ);
    localparam int unsigned CW         = $clog2(NUM_REGS + 1);
    localparam int unsigned LOAD_LIMIT = (SYS_CLK_HZ / 1000) * 30;
    localparam int unsigned LW         = $clog2(LOAD_LIMIT + 1);

    typedef struct packed {
        seq_state_e   state;
        logic         issued;
        logic [CW-1:0] byte_cnt;
        logic         sig_ok;
        logic         fail;
        logic         we;
        logic [6:0]   waddr;
        logic [7:0]   wdata;
        logic         done;
        logic         valid;
    } seq_s;

    seq_s q, n;
    logic       tick, eng_done, eng_nack, cmd_valid, send_ack;
    logic [7:0] eng_rdata, cmd_wdata;
    bus_cmd_e   cmd;

    boot_cfg_tick #(.QTR_DIV(QTR_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    boot_cfg_bit_engine u_engine (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .cmd_valid(cmd_valid), .cmd(cmd), .wdata(cmd_wdata), .send_ack(send_ack),
        .sda_in(sda_in), .done(eng_done), .rdata(eng_rdata), .nack(eng_nack),
        .scl_oe(scl_oe), .sda_oe(sda_oe)
    );

    always_comb begin
        n         = q;
        n.we      = 1'b0;
        cmd       = BC_START;
        cmd_wdata = 8'h00;
        send_ack  = 1'b0;
        unique case (q.state)
            SQ_WAIT:   if (mode_sel == 2'b00 && !pwr_down) n.state = SQ_START;
            SQ_START,
            SQ_RSTART: cmd = BC_START;
            SQ_DEVW:   begin cmd = BC_WRITE; cmd_wdata = {DEV_ADDR, 1'b0}; end
            SQ_WADDR:  begin cmd = BC_WRITE; cmd_wdata = 8'h00; end
            SQ_DEVR:   begin cmd = BC_WRITE; cmd_wdata = {DEV_ADDR, 1'b1}; end
            SQ_READ:   begin cmd = BC_READ; send_ack = (q.byte_cnt != CW'(NUM_REGS)); end
            SQ_STOP:   cmd = BC_STOP;
            default:   ;
        endcase
        cmd_valid = !q.issued && (q.state != SQ_WAIT) && (q.state != SQ_DONE);
        if (cmd_valid) n.issued = 1'b1;

        if (eng_done) begin
            n.issued = 1'b0;
            unique case (q.state)
                SQ_START:  n.state = SQ_DEVW;
                SQ_RSTART: n.state = SQ_DEVR;
                SQ_DEVW, SQ_WADDR, SQ_DEVR: begin
                    if (eng_nack) begin
                        n.fail  = 1'b1;
                        n.state = SQ_STOP;
                    end else begin
                        n.state    = (q.state == SQ_DEVW)  ? SQ_WADDR :
                                     (q.state == SQ_WADDR) ? SQ_RSTART : SQ_READ;
                        n.byte_cnt = '0;
                    end
                end
                SQ_READ: begin
                    if (q.byte_cnt == '0) begin
                        n.sig_ok = (eng_rdata == SIGNATURE);
                    end else if (q.sig_ok) begin
                        n.we    = 1'b1;
                        n.waddr = 7'(q.byte_cnt - 1'b1);
                        n.wdata = eng_rdata;
                    end
                    if (q.byte_cnt == CW'(NUM_REGS)) n.state = SQ_STOP;
                    else                             n.byte_cnt = q.byte_cnt + 1'b1;
                end
                SQ_STOP: begin
                    n.state = SQ_DONE;
                    n.done  = 1'b1;
                    n.valid = q.sig_ok && !q.fail;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= SQ_WAIT;
        end else begin
            q <= n;
        end
    end

    assign reg_addr   = q.waddr;
    assign reg_data   = q.wdata;
    assign reg_we     = q.we;
    assign load_done  = q.done;
    assign load_valid = q.valid;

    // Cycle budget watch for R10
    logic [LW-1:0] run_cnt_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_cnt_q <= '0;
        else if (q.state != SQ_WAIT && q.state != SQ_DONE) run_cnt_q <= run_cnt_q + 1'b1;
    end

    a_r10_load_budget: assert property (@(posedge clk) disable iff (!rst_n)
        run_cnt_q < LW'(LOAD_LIMIT));

    a_r11_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |=> (load_done && $stable(load_valid)));

    a_r11_valid_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
        load_valid |-> load_done);

    // R4/R5: register writes happen only before completion
    a_r4_write_before_done: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> !load_done);

    // R8/R9: while held off the bus is left released
    a_r8_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == SQ_WAIT) |-> (!scl_oe && !sda_oe));

endmodule

// File: tb/boot_cfg_loader_bench.sv
`timescale 1ns/1ps
module boot_cfg_loader_bench;
    localparam int SYS_HZ = 4_000_000;
    localparam int SCL_F  = 500_000;
    localparam int QTR    = SYS_HZ / (4 * SCL_F);
    localparam int CLK_NS = 4;
    localparam int LIMIT  = (SYS_HZ / 1000) * 30;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] mode_sel = 2'b00;
    logic pwr_down = 1'b0;
    logic scl_oe, sda_oe, reg_we, load_done, load_valid;
    logic [6:0] reg_addr;
    logic [7:0] reg_data;
    wire scl_w, sda_w;
    logic slv_oe;

    always #(CLK_NS/2) clk = ~clk;

    assign scl_w = !scl_oe;
    assign sda_w = !(sda_oe || slv_oe);

    boot_cfg_loader #(.SYS_CLK_HZ(SYS_HZ), .SCL_HZ(SCL_F)) u_boot_cfg_loader (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .pwr_down(pwr_down),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_w),
        .reg_addr(reg_addr), .reg_data(reg_data), .reg_we(reg_we),
        .load_done(load_done), .load_valid(load_valid)
    );

    int total = 0;
    int bad = 0;
    logic [7:0] mem [0:255];
    int nack_at = 0;

    // EEPROM model state
    logic prev_scl, prev_sda, skip, active, txm, rd_req, nack_now, mack;
    int bc, nstart, nstop, nlog, nread, macks, nack_pos, per_bad, per_n;
    logic [7:0] sh, txb, ptr;
    logic [7:0] blog [0:3];
    longint last_rise;

    always @(scl_w, sda_w, rst_n) begin
        if (!rst_n) begin
            slv_oe = 1'b0; skip = 1'b0; active = 1'b0; txm = 1'b0; rd_req = 1'b0;
            nack_now = 1'b0; mack = 1'b0; bc = 0; nstart = 0; nstop = 0; nlog = 0;
            nread = 0; macks = 0; nack_pos = 0; per_bad = 0; per_n = 0; sh = 8'h00;
            txb = 8'h00; ptr = 8'h00; last_rise = 0;
        end else if (scl_w && prev_scl && sda_w != prev_sda) begin
            if (!sda_w) begin
                nstart++; bc = 0; txm = 1'b0; slv_oe = 1'b0; skip = 1'b1; active = 1'b1;
            end else begin
                nstop++; txm = 1'b0; slv_oe = 1'b0; active = 1'b0;
            end
        end else if (scl_w && !prev_scl) begin
            if (active && txm) begin
                if (bc == 8) mack = sda_w;
                else if (bc == 0) last_rise = $time;
                else begin
                    per_n++;
                    if ($time - last_rise != 4 * QTR * CLK_NS) per_bad++;
                    last_rise = $time;
                end
            end else if (active && bc < 8) begin
                sh = {sh[6:0], sda_w};
            end
        end else if (!scl_w && prev_scl) begin
            if (skip) skip = 1'b0;
            else if (active) begin
                bc++;
                if (!txm) begin
                    if (bc == 8) begin
                        if (nlog < 4) blog[nlog] = sh;
                        nlog++;
                        nack_now = (nack_at == nlog);
                        slv_oe = !nack_now;
                        if (nlog == 2) ptr = sh;
                        rd_req = sh[0] && !nack_now;
                    end else if (bc == 9) begin
                        slv_oe = 1'b0; bc = 0;
                        if (nack_now) active = 1'b0;
                        if (rd_req) begin
                            rd_req = 1'b0; txm = 1'b1; txb = mem[ptr]; slv_oe = !txb[7];
                        end
                    end
                end else begin
                    if (bc < 8) slv_oe = !txb[7-bc];
                    else if (bc == 8) slv_oe = 1'b0;
                    else begin
                        bc = 0; nread++;
                        if (mack) begin nack_pos = nread; active = 1'b0; txm = 1'b0; end
                        else begin macks++; ptr++; txb = mem[ptr]; slv_oe = !txb[7]; end
                    end
                end
            end
        end
        prev_scl = scl_w;
        prev_sda = sda_w;
    end

    // register-file write monitor, sampled on the falling clock edge
    int wr_idx, wr_bad;
    always @(negedge clk) begin
        if (!rst_n) begin
            wr_idx <= 0; wr_bad <= 0;
        end else if (reg_we) begin
            if (wr_idx >= 128 || int'(reg_addr) != wr_idx || reg_data != mem[wr_idx+1])
                wr_bad <= wr_bad + 1;
            wr_idx <= wr_idx + 1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic fill_image(input logic [7:0] sig);
        for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
        mem[0] = sig;
    endtask

    task automatic begin_run(input logic [1:0] m, input logic p, input int nk);
        rst_n = 1'b0; mode_sel = m; pwr_down = p; nack_at = nk;
        repeat (4) @(negedge clk);
        check(!load_done && !load_valid && !scl_oe && !sda_oe && !reg_we, "R11 reset state",
              int'({load_done, load_valid, scl_oe, sda_oe, reg_we}), 0);
        rst_n = 1'b1;
    endtask

    task automatic wait_done(output int cyc);
        cyc = 0;
        while (!load_done && cyc < 30000) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic good_load_checks(input int cyc);
        check(load_done, "R1 load completes", int'(load_done), 1);
        check(load_valid, "R4 valid after good image", int'(load_valid), 1);
        check(wr_idx == 128, "R4 write count", wr_idx, 128);
        check(wr_bad == 0, "R4 write address/data", wr_bad, 0);
        check(blog[0] == 8'hA0 && blog[1] == 8'h00 && blog[2] == 8'hA1, "R2 addressing bytes",
              int'({blog[0], blog[1], blog[2]}), 32'hA000A1);
        check(nstart == 2 && nstop == 1, "R2 R3 start/stop count", nstart * 10 + nstop, 21);
        check(nread == 129 && macks == 128, "R6 reads acked", nread * 1000 + macks, 129128);
        check(nack_pos == 129, "R6 final nack", nack_pos, 129);
        check(cyc < LIMIT, "R10 load time", cyc, LIMIT);
        check(per_n > 0 && per_bad == 0, "R12 scl period", per_bad, 0);
        repeat (40) @(negedge clk);
        check(load_done && load_valid, "R11 status held", int'({load_done, load_valid}), 3);
    endtask

    initial begin
        int cyc;
        void'($urandom(32'h5EED_1234));

        // two random images with a correct signature
        for (int k = 0; k < 2; k++) begin
            fill_image(8'h95);
            begin_run(2'b00, 1'b0, 0);
            wait_done(cyc);
            good_load_checks(cyc);
        end

        // near-miss signatures
        fill_image(8'h94);
        begin_run(2'b00, 1'b0, 0);
        wait_done(cyc);
        check(load_done && !load_valid, "R5 status on 0x94", int'({load_done, load_valid}), 2);
        check(wr_idx == 0, "R5 no writes on 0x94", wr_idx, 0);
        check(nread == 129, "R5 transfer still completes", nread, 129);
        fill_image(8'h59);
        begin_run(2'b00, 1'b0, 0);
        wait_done(cyc);
        check(load_done && !load_valid, "R5 status on 0x59", int'({load_done, load_valid}), 2);
        check(wr_idx == 0, "R5 no writes on 0x59", wr_idx, 0);

        // missing acknowledge on each addressing byte
        for (int nk = 1; nk <= 3; nk++) begin
            fill_image(8'h95);
            begin_run(2'b00, 1'b0, nk);
            wait_done(cyc);
            check(load_done && !load_valid, "R7 abort status", int'({load_done, load_valid}), 2);
            check(wr_idx == 0 && nread == 0, "R7 no data phase", wr_idx + nread, 0);
            check(nstop == 1, "R7 stop issued", nstop, 1);
        end

        // power-down hold-off, then release
        fill_image(8'h95);
        begin_run(2'b00, 1'b1, 0);
        repeat (600) @(negedge clk);
        check(nstart == 0 && !scl_oe && !sda_oe && !load_done, "R8 held during power-down",
              nstart, 0);
        pwr_down = 1'b0;
        wait_done(cyc);
        check(load_done && load_valid && wr_idx == 128, "R8 load after release", wr_idx, 128);

        // other mode selections keep the loader silent
        for (int m = 1; m < 4; m++) begin
            begin_run(2'(m), 1'b0, 0);
            repeat (500) @(negedge clk);
            check(nstart == 0 && !scl_oe && !sda_oe && !load_done, "R9 silent in other mode",
                  nstart, 0);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule